// File: doc/BRIEF.md
# SDRAM Burst Data Path with Byte-Lane Masking

This block sequences the data beats of read and write bursts on a 96-bit synchronous DRAM data bus. A command decoder upstream accepts a read or write and pulses `cmd_go` together with the burst direction, length, CAS latency, column order and starting column. From the next cycle on, the block steps through the beats. For each beat it drives the column address and, for writes, a write enable for each byte lane. For reads it produces a data-valid strobe delayed by the CAS latency. On the last data beat of a burst that ran to completion it pulses a done flag, which the decoder can use to issue a pending auto-precharge.

Two mask inputs gate the write data with zero latency, each covering every other byte lane. A clock-enable input suspends the burst: a low level freezes the engine from the following clock edge. When the enable returns high, the burst picks up at the beat where it stopped, starting from the second edge after the return. A new command during a burst cuts that burst short and starts the new one on the next cycle. This lets bursts to alternating banks run back to back with no idle beat.

Top module: `sdr_burst_path`

## Requirements
- R1: While reset is applied and in the first cycle after it, `byte_we` is all zero and `rd_valid` and `burst_done` are low.
- R2: A write command accepted with `cmd_wr`=1 and `cmd_blen`=b gives 2^b consecutive beat cycles, starting the cycle after the command. In each beat, lane i (data bits 8i..8i+7) has `byte_we[i]` high unless its mask is high. Outside write beats `byte_we` is zero.
- R3: Masking has zero latency and is judged independently in every cycle. `mask_lo` high clears the enables of the even lanes (bits 0-7, 16-23, 32-39, 48-55, 64-71, 80-87) in that same cycle. `mask_hi` high does the same for the odd lanes (bits 8-15, 24-31, 40-47, 56-63, 72-79, 88-95).
- R4: With `cmd_ilv`=0, beat k drives `col_off` equal to `cmd_col` with its low b bits replaced by (low b bits of `cmd_col` + k) mod 2^b.
- R5: With `cmd_ilv`=1, beat k drives `col_off` equal to `cmd_col` with its low b bits replaced by (low b bits of `cmd_col`) XOR k.
- R6: For a read command (`cmd_wr`=0) with `cmd_cl`=c (1 to 3), `rd_valid` is high during 2^b non-suspended cycles. The first of these is c cycles after the command cycle when no suspend intervenes.
- R7: If `cke` is low in cycle n, cycle n+1 is a suspended cycle. In it `byte_we` is zero, `rd_valid` and `burst_done` are low, and the beat position and read latency pipeline do not advance, so `col_off` holds. The burst resumes at the beat where it stopped in the first cycle whose predecessor had `cke` high.
- R8: A `cmd_go` presented in a suspended cycle is ignored.
- R9: A command presented in the last beat of a burst starts the new burst's first beat in the next cycle, with no idle cycle in between.
- R10: A command presented during a burst ends that burst after the current beat. The new burst's first beat follows in the next cycle, and the interrupted burst gives no `burst_done` pulse.
- R11: `burst_done` is high for one cycle with the final write beat of a completed write burst, and with the final `rd_valid` cycle of a completed read burst.
- R12: `arr_wdata` follows `wdata` in non-suspended cycles and repeats its previous value in suspended cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_go | input | 1 | Read or write command accepted by the decoder |
| cmd_wr | input | 1 | Direction of the command: 1 write, 0 read |
| cmd_blen | input | 2 | Burst length code b; the burst has 2^b beats (1 to 8) |
| cmd_cl | input | 2 | CAS latency in cycles, 1 to 3 |
| cmd_ilv | input | 1 | Column order: 0 sequential, 1 interleaved |
| cmd_col | input | 8 | Starting column |
| mask_lo | input | 1 | Write mask for the even byte lanes |
| mask_hi | input | 1 | Write mask for the odd byte lanes |
| cke | input | 1 | Clock enable; low requests a suspend |
| wdata | input | 96 | Write data from the host side |
| byte_we | output | 12 | Per-lane write enable for the current beat |
| col_off | output | 8 | Column address of the current beat |
| arr_wdata | output | 96 | Write data toward the array, frozen while suspended |
| rd_valid | output | 1 | Read data valid for the current cycle |
| burst_done | output | 1 | Last data beat of a completed burst |

## Verification
The properties assume that `cmd_blen` never exceeds the longest supported burst. They also assume that `cmd_cl` stays in 1 to 3 and changes only once the engine is idle and every read beat in flight has left the latency pipeline. Otherwise two read streams with different delays could land on the same cycle. The stimulus holds the latency fixed through each random segment and through each directed read. Between segments it inserts idle cycles with the clock enable high, and it draws burst codes only from the legal range. Inside those limits it varies direction, order, start column, masks, suspends and command timing freely, including commands issued during a suspend.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

   // One read beat travelling through the CAS latency pipeline.
   typedef struct packed {
      logic vld;
      logic last;
   } rd_tok_t;

   typedef enum logic {
      DIR_RD = 1'b0,
      DIR_WR = 1'b1
   } dir_e;

endpackage

// File: rtl/sdr_burst_seq.sv
// Beat sequencer: holds the active burst, counts beats and forms the column.
module sdr_burst_seq #(
   parameter int COL_W  = 8,
   parameter int MAX_BL = 8,
   parameter int ILV_EN = 1,
   parameter int IDX_W  = 3,
   parameter int BLC_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall,
   input  logic             go,
   input  logic             go_wr,
   input  logic [BLC_W-1:0] go_blc,
   input  logic             go_ilv,
   input  logic [COL_W-1:0] go_col,
   output logic             beat,
   output logic             beat_wr,
   output logic             beat_last,
   output logic [COL_W-1:0] col
);
   import sdr_burst_pkg::*;

   generate
      if (IDX_W != $clog2(MAX_BL)) begin : g_bad_idx
         $error("sdr_burst_seq: IDX_W does not match MAX_BL");
      end
   endgenerate

   logic             act_q;
   dir_e             dir_q;
   logic [IDX_W-1:0] idx_q;
   logic [BLC_W-1:0] blc_q;
   logic             ilv_q;
   logic [COL_W-1:0] start_q;
   logic [IDX_W-1:0] last_idx;
   logic             at_last;

   assign last_idx = IDX_W'((1 << blc_q) - 1);
   assign at_last  = (idx_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         dir_q   <= DIR_RD;
         idx_q   <= '0;
         blc_q   <= '0;
         ilv_q   <= 1'b0;
         start_q <= '0;
      end else if (!stall) begin
         if (go) begin
            act_q   <= 1'b1;
            dir_q   <= go_wr ? DIR_WR : DIR_RD;
            idx_q   <= '0;
            blc_q   <= go_blc;
            ilv_q   <= go_ilv;
            start_q <= go_col;
         end else if (act_q) begin
            if (at_last) act_q <= 1'b0;
            else         idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   // Column: low bits inside the burst window move, the rest stay put.
   logic [COL_W-1:0] idx_ext;
   logic [COL_W-1:0] wrap_mask;
   logic [COL_W-1:0] low_seq;
   logic [COL_W-1:0] low_sel;

   assign idx_ext = COL_W'(idx_q);
   assign low_seq = start_q + idx_ext;

   always_comb begin
      for (int b = 0; b < COL_W; b++) begin
         wrap_mask[b] = (b < int'(blc_q));
      end
   end

   generate
      if (ILV_EN != 0) begin : g_ilv
         assign low_sel = ilv_q ? (start_q ^ idx_ext) : low_seq;
      end else begin : g_seq_only
         assign low_sel = low_seq;
      end
   endgenerate

   assign col       = (start_q & ~wrap_mask) | (low_sel & wrap_mask);
   assign beat      = act_q & ~stall;
   assign beat_wr   = beat & (dir_q == DIR_WR);
   assign beat_last = at_last;

endmodule

// File: rtl/sdr_lane_gate.sv
// Byte-lane write enables with zero-latency masks, and the frozen data bus.
module sdr_lane_gate #(
   parameter int DATA_W = 96,
   parameter int LANES  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic              wr_beat,
   input  logic              mask_lo,
   input  logic              mask_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  byte_we,
   output logic [DATA_W-1:0] arr_wdata
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         if (g % 2 == 0) begin : g_even
            assign byte_we[g] = wr_beat & ~mask_lo;
         end else begin : g_odd
            assign byte_we[g] = wr_beat & ~mask_hi;
         end
      end
   endgenerate

   logic [DATA_W-1:0] frozen_q;

   assign arr_wdata = stall ? frozen_q : wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frozen_q <= '0;
      else        frozen_q <= arr_wdata;
   end

endmodule

// File: rtl/sdr_rd_pipe.sv
// CAS latency pipeline for read beats, frozen while suspended.
module sdr_rd_pipe #(
   parameter int MAX_CL = 3,
   parameter int CL_W   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    stall,
   input  sdr_burst_pkg::rd_tok_t  issue,
   input  logic [CL_W-1:0]         cl,
   output sdr_burst_pkg::rd_tok_t  out
);
   import sdr_burst_pkg::*;

   generate
      if (MAX_CL == 1) begin : g_direct
         logic unused_cl;
         assign unused_cl = ^{cl, clk, rst_n, stall};
         assign out       = issue;
      end else begin : g_stages
         rd_tok_t stg_q [1:MAX_CL-1];
         rd_tok_t tap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int j = 1; j < MAX_CL; j++) stg_q[j] <= '0;
            end else if (!stall) begin
               stg_q[1] <= issue;
               for (int j = 2; j < MAX_CL; j++) stg_q[j] <= stg_q[j-1];
            end
         end

         always_comb begin
            tap = issue;
            for (int j = 1; j < MAX_CL; j++) begin
               if (cl == CL_W'(j + 1)) tap = stg_q[j];
            end
         end

         assign out.vld  = tap.vld  & ~stall;
         assign out.last = tap.last & ~stall;
      end
   endgenerate

endmodule

// File: rtl/sdr_burst_path.sv
// Burst data engine for a wide SDRAM data bus.
module sdr_burst_path #(
   parameter int DATA_W = 96,
   parameter int LANE_W = 8,
   parameter int COL_W  = 8,
   parameter int MAX_BL = 8,
   parameter int MAX_CL = 3,
   parameter int ILV_EN = 1,
   localparam int LANES = DATA_W / LANE_W,
   localparam int IDX_W = $clog2(MAX_BL),
   localparam int BLC_W = $clog2(IDX_W + 1),
   localparam int CL_W  = $clog2(MAX_CL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic              cmd_wr,
   input  logic [BLC_W-1:0]  cmd_blen,
   input  logic [CL_W-1:0]   cmd_cl,
   input  logic              cmd_ilv,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic              mask_lo,
   input  logic              mask_hi,
   input  logic              cke,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  byte_we,
   output logic [COL_W-1:0]  col_off,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              rd_valid,
   output logic              burst_done
);
   import sdr_burst_pkg::*;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("sdr_burst_path: DATA_W must be a multiple of LANE_W");
      end
      if (LANES % 2 != 0) begin : g_bad_pair
         $error("sdr_burst_path: two masks need an even lane count");
      end
      if (MAX_BL < 2 || (MAX_BL & (MAX_BL - 1)) != 0) begin : g_bad_bl
         $error("sdr_burst_path: MAX_BL must be a power of two, at least 2");
      end
      if (MAX_BL > (1 << COL_W)) begin : g_bad_col
         $error("sdr_burst_path: burst window wider than the column");
      end
      if (MAX_CL < 1) begin : g_bad_cl
         $error("sdr_burst_path: MAX_CL must be at least 1");
      end
   endgenerate

   // Suspend: cke seen low makes the following cycle a frozen one.
   logic hold_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= ~cke;
   end

   logic [CL_W-1:0] cl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cl_q <= CL_W'(1);
      else if (!hold_q && cmd_go) cl_q <= cmd_cl;
   end

   logic beat;
   logic wr_beat;
   logic beat_last;

   sdr_burst_seq #(
      .COL_W  (COL_W),
      .MAX_BL (MAX_BL),
      .ILV_EN (ILV_EN),
      .IDX_W  (IDX_W),
      .BLC_W  (BLC_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall     (hold_q),
      .go        (cmd_go),
      .go_wr     (cmd_wr),
      .go_blc    (cmd_blen),
      .go_ilv    (cmd_ilv),
      .go_col    (cmd_col),
      .beat      (beat),
      .beat_wr   (wr_beat),
      .beat_last (beat_last),
      .col       (col_off)
   );

   sdr_lane_gate #(
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall     (hold_q),
      .wr_beat   (wr_beat),
      .mask_lo   (mask_lo),
      .mask_hi   (mask_hi),
      .wdata     (wdata),
      .byte_we   (byte_we),
      .arr_wdata (arr_wdata)
   );

   rd_tok_t rd_issue;
   rd_tok_t rd_out;

   assign rd_issue.vld  = beat & ~wr_beat;
   assign rd_issue.last = beat & ~wr_beat & beat_last;

   sdr_rd_pipe #(
      .MAX_CL (MAX_CL),
      .CL_W   (CL_W)
   ) u_rdpipe (
      .clk   (clk),
      .rst_n (rst_n),
      .stall (hold_q),
      .issue (rd_issue),
      .cl    (cl_q),
      .out   (rd_out)
   );

   assign rd_valid   = rd_out.vld;
   assign burst_done = (wr_beat & beat_last) | (rd_out.vld & rd_out.last);

endmodule

// File: rtl/sdr_burst_chk.sv
// Property checker attached to the burst data path.
module sdr_burst_chk #(
   parameter int DATA_W = 96,
   parameter int LANES  = 12,
   parameter int COL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              mask_lo,
   input logic              mask_hi,
   input logic [LANES-1:0]  byte_we,
   input logic [COL_W-1:0]  col_off,
   input logic [DATA_W-1:0] arr_wdata,
   input logic              rd_valid,
   input logic              burst_done,
   input logic              wr_beat
);

   function automatic logic [LANES-1:0] even_lanes();
      logic [LANES-1:0] v;
      v = '0;
      for (int i = 0; i < LANES; i += 2) v[i] = 1'b1;
      return v;
   endfunction

   localparam logic [LANES-1:0] EVEN = even_lanes();

   logic [1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_q <= 2'd0;
      else if (since_q != 2'd2) since_q <= since_q + 2'd1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (byte_we == '0) && !rd_valid && !burst_done);

   p_we_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we != '0) |-> wr_beat);

   p_mask_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_lo |-> ((byte_we & EVEN) == '0));

   p_mask_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_hi |-> ((byte_we & ~EVEN) == '0));

   p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q != 2'd0 && $past(!cke)) |-> (byte_we == '0) && !rd_valid && !burst_done);

   p_col_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q == 2'd2 && $past(!cke, 2)) |-> $stable(col_off));

   p_bus_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q != 2'd0 && $past(!cke)) |-> $stable(arr_wdata));

   p_done_on_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (rd_valid || wr_beat));

endmodule

bind sdr_burst_path sdr_burst_chk #(
   .DATA_W (DATA_W),
   .LANES  (LANES),
   .COL_W  (COL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cke        (cke),
   .mask_lo    (mask_lo),
   .mask_hi    (mask_hi),
   .byte_we    (byte_we),
   .col_off    (col_off),
   .arr_wdata  (arr_wdata),
   .rd_valid   (rd_valid),
   .burst_done (burst_done),
   .wr_beat    (wr_beat)
);

// File: tb/sim_sdr_burst_path.sv
module sim_sdr_burst_path;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 96;
   localparam int LANES  = 12;
   localparam int COL_W  = 8;
   localparam int MAX_CL = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic d_go = 1'b0, d_wr = 1'b0, d_ilv = 1'b0;
   logic d_mlo = 1'b0, d_mhi = 1'b0, d_cke = 1'b1;
   logic [1:0] d_blen = 2'd0;
   logic [1:0] d_cl = 2'd1;
   logic [COL_W-1:0] d_col = '0;
   logic [DATA_W-1:0] d_wd = '0;

   logic [LANES-1:0]  o_we;
   logic [COL_W-1:0]  o_col;
   logic [DATA_W-1:0] o_wd;
   logic              o_rdv, o_done;

   sdr_burst_path u0 (
      .clk(clk), .rst_n(rst_n), .cmd_go(d_go), .cmd_wr(d_wr), .cmd_blen(d_blen),
      .cmd_cl(d_cl), .cmd_ilv(d_ilv), .cmd_col(d_col), .mask_lo(d_mlo),
      .mask_hi(d_mhi), .cke(d_cke), .wdata(d_wd), .byte_we(o_we),
      .col_off(o_col), .arr_wdata(o_wd), .rd_valid(o_rdv), .burst_done(o_done)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   string ph = "";

   // Reference state built from the requirements.
   bit m_hold, m_act, m_wr, m_ilv;
   int m_idx, m_blc, m_cl;
   logic [COL_W-1:0] m_start;
   bit pv [0:MAX_CL];
   bit pl [0:MAX_CL];
   logic [DATA_W-1:0] m_wdh;

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s%s actual %h expected %h", ph, tag, act, exp);
      end
   endtask

   function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int idx, int blc, bit ilv);
      logic [COL_W-1:0] lo;
      logic [COL_W-1:0] bm;
      lo = ilv ? (s ^ COL_W'(idx)) : (s + COL_W'(idx));
      bm = COL_W'((1 << blc) - 1);
      return (s & ~bm) | (lo & bm);
   endfunction

   task automatic step();
      bit stall, beat, last, iv, il, ov, ol;
      int d;
      string t;
      logic [LANES-1:0] e_we;
      logic [DATA_W-1:0] e_wd;
      #(CLK_P/2 - 1);
      stall = m_hold;
      last  = (m_idx == (1 << m_blc) - 1);
      beat  = m_act && !stall;
      iv    = beat && !m_wr;
      il    = iv && last;
      d     = (m_cl <= 1) ? 0 : ((m_cl > MAX_CL) ? MAX_CL - 1 : m_cl - 1);
      ov    = (d == 0) ? iv : (pv[d] && !stall);
      ol    = (d == 0) ? il : (pl[d] && !stall);
      for (int i = 0; i < LANES; i++)
         e_we[i] = beat && m_wr && !((i % 2 == 0) ? d_mlo : d_mhi);
      e_wd = stall ? m_wdh : d_wd;
      if (stall) t = "R7";
      else if (d_mlo || d_mhi) t = "R3";
      else t = "R2";
      chk(t, 128'(o_we), 128'(e_we));
      if (m_act) begin
         if (stall) t = "R7";
         else if (m_ilv) t = "R5";
         else t = "R4";
         chk(t, 128'(o_col), 128'(exp_col(m_start, m_idx, m_blc, m_ilv)));
      end
      if (stall) t = "R7"; else t = "R6";
      chk(t, 128'(o_rdv), 128'(ov));
      chk("R11", 128'(o_done), 128'((beat && m_wr && last) || (ov && ol)));
      chk("R12", 128'(o_wd), 128'(e_wd));
      @(posedge clk);
      m_wdh = e_wd;
      if (!stall) begin
         for (int j = MAX_CL - 1; j >= 2; j--) begin
            pv[j] = pv[j-1];
            pl[j] = pl[j-1];
         end
         pv[1] = iv;
         pl[1] = il;
         if (d_go) begin
            m_act = 1; m_wr = d_wr; m_idx = 0; m_blc = int'(d_blen);
            m_ilv = d_ilv; m_start = d_col; m_cl = int'(d_cl);
         end else if (m_act) begin
            if (last) m_act = 0;
            else m_idx++;
         end
      end
      m_hold = !d_cke;
      @(negedge clk);
   endtask

   task automatic cmd(bit wr, int blc, int cl, bit ilv, int col);
      d_go = 1'b1; d_wr = wr; d_blen = 2'(blc); d_cl = 2'(cl);
      d_ilv = ilv; d_col = COL_W'(col);
      d_wd = {$urandom, $urandom, $urandom};
      step();
      d_go = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         d_wd = {$urandom, $urandom, $urandom};
         step();
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog all-R actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      m_hold = 0; m_act = 0; m_wr = 0; m_ilv = 0;
      m_idx = 0; m_blc = 0; m_cl = 1; m_start = '0; m_wdh = '0;
      for (int j = 0; j <= MAX_CL; j++) begin pv[j] = 0; pl[j] = 0; end

      repeat (3) @(negedge clk);
      #1;
      chk("R1", 128'(o_we), 128'(0));
      chk("R1", 128'(o_rdv), 128'(0));
      chk("R1", 128'(o_done), 128'(0));
      rst_n = 1'b1;
      idle(2);

      ph = "R2 R4 ";
      cmd(1, 2, 1, 0, 'h35);
      idle(5);

      ph = "R3 R5 ";
      cmd(1, 3, 1, 1, 'h5A);
      for (int k = 0; k < 8; k++) begin
         d_mlo = k[0]; d_mhi = k[1];
         idle(1);
      end
      d_mlo = 0; d_mhi = 0;
      idle(3);

      ph = "R6 ";
      cmd(0, 2, 3, 0, 'h17);
      idle(8);
      cmd(0, 1, 1, 1, 'h03);
      idle(4);
      cmd(0, 3, 2, 0, 'hF9);
      idle(12);

      ph = "R7 R8 R12 ";
      cmd(1, 3, 2, 0, 'h40);
      idle(2);
      d_cke = 0; idle(1);
      d_go = 1; d_wr = 0; d_col = 'hAA; idle(2);
      d_cke = 1; idle(1);
      d_go = 0; idle(10);
      cmd(0, 3, 3, 1, 'h21);
      idle(3);
      d_cke = 0; idle(1);
      d_go = 1; idle(1);
      d_cke = 1; idle(1);
      d_go = 0; idle(14);

      ph = "R9 ";
      cmd(1, 1, 2, 0, 'h10);
      idle(1);
      cmd(1, 2, 2, 1, 'h22);
      idle(3);
      cmd(0, 1, 2, 0, 'h31);
      idle(1);
      cmd(0, 0, 2, 0, 'h44);
      cmd(0, 2, 2, 0, 'h55);
      idle(10);

      ph = "R10 ";
      cmd(0, 3, 2, 0, 'h60);
      idle(3);
      cmd(1, 2, 2, 0, 'h70);
      idle(8);

      ph = "";
      for (int seg = 1; seg <= MAX_CL; seg++) begin
         for (int c = 0; c < 600; c++) begin
            d_go   = ($urandom % 5) == 0;
            d_wr   = $urandom % 2;
            d_blen = 2'($urandom % 4);
            d_cl   = 2'(seg);
            d_ilv  = $urandom % 2;
            d_col  = COL_W'($urandom);
            d_mlo  = ($urandom % 4) == 0;
            d_mhi  = ($urandom % 4) == 0;
            d_cke  = ($urandom % 8) != 0;
            d_wd   = {$urandom, $urandom, $urandom};
            step();
         end
         d_go = 0; d_cke = 1; d_mlo = 0; d_mhi = 0;
         idle(14);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule